// File: doc/BRIEF.md
# Sequential Signed Divider with Divisor Alignment

This block divides one 32-bit two's-complement number by another over several clock cycles and returns a truncated quotient and a remainder. It first takes the magnitude of both operands. It then doubles a working copy of the divisor until that copy is just above half the dividend. After that, a restoring loop halves the copy step by step and builds the quotient one bit per step. The loop ends on the step where the copy is back to the original divisor. Small quotients therefore finish in a few cycles, and a full 32-step run is needed only when the quotient is large.

A one-cycle `start` pulse loads the operands while the block is idle. `busy` stays high while the operation runs. `done` pulses for one cycle when the results are ready, and the results then stay on the outputs until the next operation completes. A zero divisor is caught straight after the magnitude step and reported on `div_by_zero`. In that case no alignment or loop cycles are spent. The signs are applied to the result at the end.

Top module: `sdiv_norm`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are 0.
- R2: A `start` sampled high while `busy` is low loads `dividend` and `divisor`, and `busy` is high from the next cycle. A `start` sampled while `busy` is high has no effect on the running operation, its result or its latency.
- R3: For a non-zero divisor, `quotient` is the signed quotient truncated toward zero. `remainder` satisfies dividend = quotient*divisor + remainder, its magnitude is below the divisor's magnitude, and it is zero or carries the sign of the dividend.
- R4: Let A and D be the operand magnitudes, and let n be the number of times D can be doubled while it stays at or below floor(A/2). Then `done` is sampled high 2n+3 clock edges after the edge that accepted `start`.
- R5: A zero divisor gives `div_by_zero`=1, `quotient`=0 and `remainder` equal to the dividend. `done` is then sampled high on the edge directly after the accepting edge.
- R6: 0x80000000 divided by 0xFFFFFFFF (-1) gives the wrapped quotient 0x80000000 and remainder 0, with no divide-by-zero flag.
- R7: `done` is high for exactly one cycle, and `busy` is low whenever `done` is high. `quotient`, `remainder` and `div_by_zero` change only on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division when idle |
| dividend | input | 32 | Signed dividend, sampled with start |
| divisor | input | 32 | Signed divisor, sampled with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results updated |
| div_by_zero | output | 1 | Last operation had a zero divisor |
| quotient | output | 32 | Signed quotient, truncated toward zero |
| remainder | output | 32 | Signed remainder, sign of dividend |

## Verification
The operands are tried in all four sign combinations with the same magnitudes. This separates the sign applied to the quotient from the sign applied to the remainder. Cases where the dividend is below the divisor, equal to it, zero, or far above it give the shortest and the longest alignment. The latency measured on each of them pins down how the alignment and loop counts follow from the data. The most negative dividend against ±1 and against the largest positive value exercises the magnitude step at its one unrepresentable input. Zero divisors, a start issued while busy, and long idle gaps after completion separate the early exit, the ignore rule and the hold of the results from the normal path. Random operand pairs with divisors of random bit length cover the remaining range.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_JUST = 2'd1,
    ST_LOOP = 2'd2,
    ST_FIN  = 2'd3
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_absval.sv
// Magnitude of a two's-complement value via sign mask: (x ^ m) - m.
module sdiv_absval #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  output logic         neg,
  output logic [W-1:0] mag
);
  logic [W-1:0] mask;
  assign neg  = val[W-1];
  assign mask = {W{val[W-1]}};
  assign mag  = (val ^ mask) - mask;
endmodule

// File: rtl/sdiv_signfix.sv
// Applies a sign to an unsigned magnitude using the same mask trick.
module sdiv_signfix #(
  parameter int W = 32
) (
  input  logic [W-1:0] mag,
  input  logic         neg,
  output logic [W-1:0] val
);
  logic [W-1:0] mask;
  assign mask = {W{neg}};
  assign val  = (mag ^ mask) - mask;
endmodule

// File: rtl/sdiv_iter.sv
// Alignment phase followed by restoring shift-subtract loop on magnitudes.
module sdiv_iter
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  output logic         busy,
  output logic         fin,
  output logic         zero_dvs,
  output logic [W-1:0] q_mag,
  output logic [W-1:0] r_mag
);
  sdiv_state_e  st, st_n;
  logic [W-1:0] rem, rem_n;
  logic [W-1:0] dv, dv_n;
  logic [W-1:0] orig, orig_n;
  logic [W-1:0] q, q_n;
  logic         dz_r, dz_n;
  logic         adv;
  logic         ge;

  assign adv = (st != ST_IDLE) || load;
  assign ge  = (rem >= dv);

  always_comb begin
    st_n   = st;
    rem_n  = rem;
    dv_n   = dv;
    orig_n = orig;
    q_n    = q;
    dz_n   = dz_r;
    case (st)
      ST_IDLE: begin
        if (load) begin
          rem_n  = dvd_mag;
          dv_n   = dvs_mag;
          orig_n = dvs_mag;
          q_n    = '0;
          dz_n   = (dvs_mag == '0);
          st_n   = (dvs_mag == '0) ? ST_FIN : ST_JUST;
        end
      end
      ST_JUST: begin
        if (dv <= (rem >> 1)) dv_n = dv << 1;
        else                  st_n = ST_LOOP;
      end
      ST_LOOP: begin
        if (ge) rem_n = rem - dv;
        q_n = {q[W-2:0], ge};
        if (dv == orig) st_n = ST_FIN;
        else            dv_n = dv >> 1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      rem  <= '0;
      dv   <= '0;
      orig <= '0;
      q    <= '0;
      dz_r <= 1'b0;
    end else if (adv) begin
      st   <= st_n;
      rem  <= rem_n;
      dv   <= dv_n;
      orig <= orig_n;
      q    <= q_n;
      dz_r <= dz_n;
    end
  end

  assign busy     = (st != ST_IDLE);
  assign fin      = (st == ST_FIN);
  assign zero_dvs = dz_r;
  assign q_mag    = q;
  assign r_mag    = rem;
endmodule

// File: rtl/sdiv_norm.sv
module sdiv_norm #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_by_zero,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  logic         neg_a, neg_b;
  logic [W-1:0] mag_a, mag_b;
  logic         sa_q, sb_q;
  logic         load;
  logic         fin, zero_dvs;
  logic [W-1:0] q_mag, r_mag;
  logic [W-1:0] q_fix, r_fix;

  sdiv_absval #(.W(W)) i_abs_a (.val(dividend), .neg(neg_a), .mag(mag_a));
  sdiv_absval #(.W(W)) i_abs_b (.val(divisor),  .neg(neg_b), .mag(mag_b));

  assign load = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q <= 1'b0;
      sb_q <= 1'b0;
    end else if (load) begin
      sa_q <= neg_a;
      sb_q <= neg_b;
    end
  end

  sdiv_iter #(.W(W)) i_iter (
    .clk(clk), .rst_n(rst_n), .load(load),
    .dvd_mag(mag_a), .dvs_mag(mag_b),
    .busy(busy), .fin(fin), .zero_dvs(zero_dvs),
    .q_mag(q_mag), .r_mag(r_mag)
  );

  sdiv_signfix #(.W(W)) i_fix_q (.mag(q_mag), .neg(sa_q ^ sb_q), .val(q_fix));
  sdiv_signfix #(.W(W)) i_fix_r (.mag(r_mag), .neg(sa_q),        .val(r_fix));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else begin
      done <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else if (fin) begin
      quotient    <= q_fix;
      remainder   <= r_fix;
      div_by_zero <= zero_dvs;
    end
  end
endmodule

// File: rtl/sdiv_norm_chk.sv
module sdiv_norm_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] dividend,
  input logic         busy,
  input logic         done,
  input logic         div_by_zero,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);
  logic [W-1:0] a_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              a_cap <= '0;
    else if (start && !busy) a_cap <= dividend;
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

  a_r5_dz_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (quotient == '0 && remainder == a_cap));

  a_r3_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero && remainder != '0) |-> (remainder[W-1] == a_cap[W-1]));

  a_r2_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind sdiv_norm sdiv_norm_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
  .busy(busy), .done(done), .div_by_zero(div_by_zero),
  .quotient(quotient), .remainder(remainder)
);

// File: tb/test_sdiv_norm.sv
`timescale 1ns/1ps
module test_sdiv_norm;
  localparam int W = 32;
  localparam int NV = 14;
  localparam logic [W-1:0] MINV = 32'h8000_0000;

  // {dividend, divisor, quotient, remainder}
  localparam logic [127:0] VEC [NV] = '{
    {32'd100,       32'd7,         32'd14,        32'd2},
    {32'hFFFFFF9C,  32'd7,         32'hFFFFFFF2,  32'hFFFFFFFE},
    {32'd100,       32'hFFFFFFF9,  32'hFFFFFFF2,  32'd2},
    {32'hFFFFFF9C,  32'hFFFFFFF9,  32'd14,        32'hFFFFFFFE},
    {32'd5,         32'd7,         32'd0,         32'd5},
    {32'd7,         32'd7,         32'd1,         32'd0},
    {32'h80000000,  32'hFFFFFFFF,  32'h80000000,  32'd0},
    {32'h80000000,  32'd1,         32'h80000000,  32'd0},
    {32'h7FFFFFFF,  32'd1,         32'h7FFFFFFF,  32'd0},
    {32'd0,         32'd5,         32'd0,         32'd0},
    {32'h7FFFFFFF,  32'h7FFFFFFF,  32'd1,         32'd0},
    {32'h80000000,  32'h7FFFFFFF,  32'hFFFFFFFF,  32'hFFFFFFFF},
    {32'd1000,      32'd3,         32'd333,       32'd1},
    {32'hFFFFFFFF,  32'd2,         32'd0,         32'hFFFFFFFF}
  };

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] dividend, divisor;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int n_chk = 0;
  int n_bad = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  sdiv_norm #(.W(W)) i_sdiv_norm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_by_zero(div_by_zero),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mag(input logic [W-1:0] x);
    return x[W-1] ? (~x + 1'b1) : x;
  endfunction

  function automatic int ref_lat(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] ma, md;
    int n;
    ma = mag(a);
    md = mag(b);
    if (md == '0) return 1;
    n = 0;
    while (md <= (ma >> 1)) begin
      md = md << 1;
      n++;
    end
    return 2 * n + 3;
  endfunction

  function automatic logic [W-1:0] ref_q(input logic [W-1:0] a, input logic [W-1:0] b);
    if (b == '0) return '0;
    if (a == MINV && b == '1) return MINV;
    return $signed(a) / $signed(b);
  endfunction

  function automatic logic [W-1:0] ref_r(input logic [W-1:0] a, input logic [W-1:0] b);
    if (b == '0) return a;
    if (a == MINV && b == '1) return '0;
    return $signed(a) % $signed(b);
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, output int lat);
    @(negedge clk);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_op(input string tag, input logic [W-1:0] a, input logic [W-1:0] b);
    int lat;
    run_op(a, b, lat);
    chk({tag, " R3 quotient"},  quotient,  ref_q(a, b));
    chk({tag, " R3 remainder"}, remainder, ref_r(a, b));
    chk({tag, " R5 dz flag"},   {31'd0, div_by_zero}, {31'd0, (b == '0)});
    chk({tag, " R4 latency"},   32'(lat), 32'(ref_lat(a, b)));
  endtask

  initial begin
    #1200000;
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    logic [W-1:0] a, b, q_keep, r_keep;
    rst_n = 1'b0;
    start = 1'b0;
    dividend = '0;
    divisor = '0;
    repeat (3) @(negedge clk);
    // R1: values under reset
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    chk("R1 quotient in reset", quotient, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 remainder after reset", remainder, 32'd0);
    chk("R1 dz after reset", {31'd0, div_by_zero}, 32'd0);

    // Table walk: R3, R4, R6
    for (int i = 0; i < NV; i++) begin
      a = VEC[i][127:96];
      b = VEC[i][95:64];
      run_op(a, b, lat);
      chk($sformatf("R3 vec%0d quotient", i),  quotient,  VEC[i][63:32]);
      chk($sformatf("R3 vec%0d remainder", i), remainder, VEC[i][31:0]);
      chk($sformatf("R4 vec%0d latency", i),   32'(lat),  32'(ref_lat(a, b)));
      if (i == 6) chk("R6 min by -1 no dz flag", {31'd0, div_by_zero}, 32'd0);
    end

    // R4: extreme latency, quotient of 2^31
    run_op(MINV, 32'd1, lat);
    chk("R4 longest latency", 32'(lat), 32'd65);

    // R5: zero divisor
    run_op(32'hFFFF_1234, 32'd0, lat);
    chk("R5 dz flag", {31'd0, div_by_zero}, 32'd1);
    chk("R5 dz quotient", quotient, 32'd0);
    chk("R5 dz remainder", remainder, 32'hFFFF_1234);
    chk("R5 dz latency", 32'(lat), 32'd1);
    check_op("R5 dz min", MINV, 32'd0);
    check_op("R5 dz clears", 32'd9, 32'd4);

    // R7: done one cycle, busy low, results held
    run_op(32'd1000, 32'd3, lat);
    chk("R7 busy low at done", {31'd0, busy}, 32'd0);
    q_keep = quotient;
    r_keep = remainder;
    @(negedge clk);
    chk("R7 done pulse width", {31'd0, done}, 32'd0);
    dividend = 32'd77;
    divisor  = 32'd5;
    repeat (10) @(negedge clk);
    chk("R7 quotient held", quotient, q_keep);
    chk("R7 remainder held", remainder, r_keep);

    // R2: start while busy is ignored
    @(negedge clk);
    dividend = 32'd1000;
    divisor  = 32'd3;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", {31'd0, busy}, 32'd1);
    lat = 0;
    repeat (2) begin @(negedge clk); lat++; end
    dividend = 32'd5;
    divisor  = 32'd1;
    start    = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    chk("R2 ignored start quotient", quotient, 32'd333);
    chk("R2 ignored start remainder", remainder, 32'd1);
    chk("R2 ignored start latency", 32'(lat), 32'd19);
    @(negedge clk);
    chk("R2 idle after op", {31'd0, busy}, 32'd0);

    // Random operands with random divisor length: R3, R4
    for (int k = 0; k < 60; k++) begin
      a = $urandom;
      b = $urandom >> ($urandom % 32);
      if ($urandom % 2 == 1) b = ~b + 1'b1;
      check_op($sformatf("rand%0d", k), a, b);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule